// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block gathers interrupt requests from peripherals and from software and presents, for each CPU, the single most urgent interrupt that is enabled, pending, routed to that CPU and not already being serviced. Each interrupt ID has an enable bit, a pending state, an active bit, an 8-bit priority, a CPU routing mask and a trigger mode. IDs 0 to 15 are software interrupts and IDs 16 to 31 are private peripheral lines, one set per CPU. These 32 low IDs keep enable, pending and active state separately for every CPU. IDs 32 and above are shared lines that can be routed to any group of CPUs.

Software configures the block through a 32-bit register port that uses word addresses. Every access carries the number of the CPU that issues it, and that number selects the banked copy of the low IDs. Each CPU interface watches its `hp_*` outputs. It takes an interrupt with an acknowledge pulse carrying the ID, which makes the interrupt active. It ends service with a completion pulse carrying the ID, which clears the active bit.

Word map: 0x00 control (bit 0 forwards interrupts), 0x01 type (read-only), 0x02 software trigger, 0x08+ enable-set, 0x10+ enable-clear, 0x18+ pending (read-only), 0x20+ trigger mode, 0x40+ priority, 0x80+ CPU routing.

Top module: `irq_distributor`

## Requirements
- R1: After reset the control bit, every enable, pending, active, priority and routing field is 0, and every `hp_valid` bit is 0.
- R2: A write to word 0x08+k sets, and a write to word 0x10+k clears, the enable of every ID 32k+b whose data bit b is 1. Bits written as 0 leave their enable unchanged. Reading either word returns the current enables.
- R3: For IDs 0 to 31, enable, pending and active state is kept per CPU, and an access issued with `req_cpu`=c sees and changes only CPU c's copy. Pending state is read at word 0x18+k.
- R4: The type word 0x01 reads NUM_IRQ/32-1 in bits 4:0 and zero elsewhere. Writes to it have no effect.
- R5: Priority word 0x40+k holds the priority of ID 4k+j in bits 8j+7:8j. Reading the word returns what was written.
- R6: Routing word 0x80+k holds a byte for ID 4k+j in bits 8j+7:8j, and bit c of that byte routes the ID to CPU c. Only the low NUM_CPU bits of each byte are stored, and the others read 0. For IDs below 32 the bytes are read-only and read as the issuing CPU's own bit.
- R7: Trigger word 0x20+k holds 2 bits for ID 16k+j at bits 2j+1:2j. The value 0 means level and bit 2j+1 set means edge. A level ID is pending while its line is high and it is not active. An edge ID latches pending on a rising edge of its line, and an acknowledge clears the latch. IDs 0 to 15 are fixed as edge and read as 2'b10.
- R8: While control bit 0 is 0, no `hp_valid` is raised, and all register state is kept.
- R9: A write to word 0x02 sets pending on software ID `wdata[3:0]` for every CPU c whose bit `wdata[16+c]` is 1.
- R10: For each CPU the presented interrupt is the enabled, pending, routed and non-active ID with the numerically lowest priority. On a tie in priority, the lower ID wins.
- R11: An acknowledge from CPU c with an ID makes that ID active, which removes it from selection. A completion with the ID clears the active bit.
- R12: `hp_*` outputs are registered and reflect state one cycle after it changes. A read accepted in one cycle gives `rsp_valid` with its data in the next cycle. `req_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always accepts |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPUW | Issuing CPU, selects the banked state |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_in | input | NUM_IRQ-32 | Shared interrupt lines, bit j is ID 32+j |
| ppi_in | input | NUM_CPU*16 | Private lines, bit 16c+k is ID 16+k of CPU c |
| ack_valid | input | NUM_CPU | Acknowledge pulse per CPU |
| ack_id | input | NUM_CPU*IDW | Acknowledged ID per CPU |
| eoi_valid | input | NUM_CPU | Completion pulse per CPU |
| eoi_id | input | NUM_CPU*IDW | Completed ID per CPU |
| hp_valid | output | NUM_CPU | An interrupt is presented to the CPU |
| hp_id | output | NUM_CPU*IDW | Presented ID per CPU |
| hp_prio | output | NUM_CPU*8 | Presented priority per CPU |

## Verification
The assertions assume that each CPU interface acknowledges only the ID it is being shown, that it does not acknowledge and complete the same ID in the same cycle, and that `req_cpu` names an existing CPU. The stimulus keeps to these rules. It acknowledges an ID only after the bench has confirmed that ID on `hp_id`, it sends each completion a few cycles after its acknowledge, and it issues accesses only from CPUs 0 and 1. Register traffic is one access at a time, so the ordering of read responses follows the ordering of requests.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int PRIV_IDS = 32;
  localparam int SGI_IDS  = 16;
  localparam int PPI_PER_CPU = 16;
  localparam int PRIO_W   = 8;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_TYPE  = 8'h01;
  localparam logic [7:0] A_SWI   = 8'h02;
  localparam logic [7:0] A_ENSET = 8'h08;
  localparam logic [7:0] A_ENCLR = 8'h10;
  localparam logic [7:0] A_PEND  = 8'h18;
  localparam logic [7:0] A_CFG   = 8'h20;
  localparam logic [7:0] A_PRIO  = 8'h40;
  localparam logic [7:0] A_TGT   = 8'h80;

  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irqd_rise.sv
module irqd_rise #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= din;
  end

  assign rise = din & ~prev_q;
endmodule

// File: rtl/irqd_prio_pick.sv
module irqd_prio_pick
  import irqd_pkg::*;
#(
  parameter int N   = 64,
  parameter int IDW = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           elig,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                   win_valid,
  output logic [IDW-1:0]         win_id,
  output prio_t                  win_prio
);
  // Ascending scan with a strict compare keeps the lower ID on equal priority.
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!win_valid || prio[i] < win_prio)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio[i];
      end
    end
  end

  // R10: a winner is always one of the eligible candidates
  p_win_eligible_r10: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> elig[win_id]);
  // R10: any eligible candidate yields a winner
  p_win_present_r10: assert property (@(posedge clk) disable iff (rst)
    (|elig) |-> win_valid);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  localparam int CPUW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IDW  = $clog2(NUM_IRQ),
  localparam int NUM_SHR = NUM_IRQ - PRIV_IDS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [CPUW-1:0]           req_cpu,
  input  logic [7:0]                req_addr,
  input  logic [31:0]               req_wdata,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_rdata,
  input  logic [NUM_SHR-1:0]        irq_in,
  input  logic [NUM_CPU*PPI_PER_CPU-1:0] ppi_in,
  input  logic [NUM_CPU-1:0]        ack_valid,
  input  logic [NUM_CPU*IDW-1:0]    ack_id,
  input  logic [NUM_CPU-1:0]        eoi_valid,
  input  logic [NUM_CPU*IDW-1:0]    eoi_id,
  output logic [NUM_CPU-1:0]        hp_valid,
  output logic [NUM_CPU*IDW-1:0]    hp_id,
  output logic [NUM_CPU*PRIO_W-1:0] hp_prio
);
  localparam int NW32 = NUM_IRQ / 32;
  localparam int NW16 = NUM_IRQ / 16;
  localparam int NW4  = NUM_IRQ / 4;

  // ---------------- state ----------------
  logic                          ctrl_en;
  logic [NUM_CPU-1:0][PRIV_IDS-1:0] en_p, act_p, lat_p;
  logic [NUM_SHR-1:0]            en_s, act_s, lat_s;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0] tgt;
  logic [NUM_IRQ-1:0]            edge_cfg;

  logic [NUM_IRQ-1:0] pend_all [NUM_CPU];
  logic [NUM_IRQ-1:0] en_all   [NUM_CPU];
  logic [IDW-1:0]     ack_id_a [NUM_CPU];
  logic [IDW-1:0]     eoi_id_a [NUM_CPU];

  logic [NUM_SHR-1:0]                 rise_s;
  logic [NUM_CPU*PPI_PER_CPU-1:0]     rise_p;

  irqd_rise #(.W(NUM_SHR)) u_rise_shr (
    .clk(clk), .rst(rst), .din(irq_in), .rise(rise_s));
  irqd_rise #(.W(NUM_CPU*PPI_PER_CPU)) u_rise_ppi (
    .clk(clk), .rst(rst), .din(ppi_in), .rise(rise_p));

  // ---------------- decode ----------------
  logic wr, rd, swi_wr;
  int   off_en, off_clr, off_pend, off_cfg, off_prio, off_tgt;

  assign wr        = req_valid & req_write;
  assign rd        = req_valid & ~req_write;
  assign swi_wr    = wr && (req_addr == A_SWI);
  assign req_ready = 1'b1;

  always_comb begin
    off_en   = int'(req_addr) - int'(A_ENSET);
    off_clr  = int'(req_addr) - int'(A_ENCLR);
    off_pend = int'(req_addr) - int'(A_PEND);
    off_cfg  = int'(req_addr) - int'(A_CFG);
    off_prio = int'(req_addr) - int'(A_PRIO);
    off_tgt  = int'(req_addr) - int'(A_TGT);
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      en_p     <= '0;
      act_p    <= '0;
      lat_p    <= '0;
      en_s     <= '0;
      act_s    <= '0;
      lat_s    <= '0;
      prio     <= '0;
      tgt      <= '0;
      edge_cfg <= {{(NUM_IRQ-SGI_IDS){1'b0}}, {SGI_IDS{1'b1}}};
    end else begin
      // acknowledge / completion from each CPU interface
      for (int c = 0; c < NUM_CPU; c++) begin
        for (int i = 0; i < PRIV_IDS; i++) begin
          if (eoi_valid[c] && int'(eoi_id_a[c]) == i) act_p[c][i] <= 1'b0;
          if (ack_valid[c] && int'(ack_id_a[c]) == i) begin
            act_p[c][i] <= 1'b1;
            lat_p[c][i] <= 1'b0;
          end
        end
        for (int j = 0; j < NUM_SHR; j++) begin
          if (eoi_valid[c] && int'(eoi_id_a[c]) == j + PRIV_IDS) act_s[j] <= 1'b0;
          if (ack_valid[c] && int'(ack_id_a[c]) == j + PRIV_IDS) begin
            act_s[j] <= 1'b1;
            lat_s[j] <= 1'b0;
          end
        end
      end
      // edge latches (set after the ack clear so a fresh edge is kept)
      for (int j = 0; j < NUM_SHR; j++)
        if (rise_s[j] && edge_cfg[j+PRIV_IDS]) lat_s[j] <= 1'b1;
      for (int c = 0; c < NUM_CPU; c++)
        for (int k = 0; k < PPI_PER_CPU; k++)
          if (rise_p[c*PPI_PER_CPU+k] && edge_cfg[SGI_IDS+k])
            lat_p[c][SGI_IDS+k] <= 1'b1;
      // software trigger
      for (int c = 0; c < NUM_CPU; c++)
        for (int i = 0; i < SGI_IDS; i++)
          if (swi_wr && req_wdata[16+c] && int'(req_wdata[3:0]) == i)
            lat_p[c][i] <= 1'b1;
      // register writes
      if (wr && req_addr == A_CTRL) ctrl_en <= req_wdata[0];
      if (wr) begin
        for (int i = 0; i < PRIV_IDS; i++) begin
          if (off_en  == 0 && req_wdata[i]) en_p[req_cpu][i] <= 1'b1;
          if (off_clr == 0 && req_wdata[i]) en_p[req_cpu][i] <= 1'b0;
        end
        for (int j = 0; j < NUM_SHR; j++) begin
          if (off_en  == (j + PRIV_IDS) / 32 && req_wdata[j%32]) en_s[j] <= 1'b1;
          if (off_clr == (j + PRIV_IDS) / 32 && req_wdata[j%32]) en_s[j] <= 1'b0;
        end
        for (int i = 0; i < NUM_IRQ; i++) begin
          if (off_prio == i / 4) prio[i] <= req_wdata[8*(i%4) +: PRIO_W];
          if (i >= PRIV_IDS && off_tgt == i / 4)
            tgt[i] <= req_wdata[8*(i%4) +: NUM_CPU];
          if (i >= SGI_IDS && off_cfg == i / 16)
            edge_cfg[i] <= req_wdata[2*(i%16)+1];
        end
      end
    end
  end

  // ---------------- read path ----------------
  logic [31:0] rd_data;
  always_comb begin
    rd_data = '0;
    if (req_addr == A_CTRL) rd_data[0] = ctrl_en;
    else if (req_addr == A_TYPE) rd_data[4:0] = 5'(NW32 - 1);
    else if (off_en >= 0 && off_en < NW32) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (i / 32 == off_en) rd_data[i%32] = en_all[req_cpu][i];
    end else if (off_clr >= 0 && off_clr < NW32) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (i / 32 == off_clr) rd_data[i%32] = en_all[req_cpu][i];
    end else if (off_pend >= 0 && off_pend < NW32) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (i / 32 == off_pend) rd_data[i%32] = pend_all[req_cpu][i];
    end else if (off_cfg >= 0 && off_cfg < NW16) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (i / 16 == off_cfg) rd_data[2*(i%16)+1] = edge_cfg[i];
    end else if (off_prio >= 0 && off_prio < NW4) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (i / 4 == off_prio) rd_data[8*(i%4) +: PRIO_W] = prio[i];
    end else if (off_tgt >= 0 && off_tgt < NW4) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (i / 4 == off_tgt) begin
          if (i < PRIV_IDS) begin
            for (int c = 0; c < NUM_CPU; c++)
              if (c == int'(req_cpu)) rd_data[8*(i%4)+c] = 1'b1;
          end else begin
            rd_data[8*(i%4) +: NUM_CPU] = tgt[i];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_data;
    end
  end

  // ---------------- per-CPU selection ----------------
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] lvl, route, pend, elig, en_v;
    logic               win_v;
    logic [IDW-1:0]     win_id;
    prio_t              win_pr;
    logic               hv_q;
    logic [IDW-1:0]     hid_q;
    prio_t              hpr_q;

    assign ack_id_a[c] = ack_id[c*IDW +: IDW];
    assign eoi_id_a[c] = eoi_id[c*IDW +: IDW];

    assign lvl = {irq_in, ppi_in[c*PPI_PER_CPU +: PPI_PER_CPU], {SGI_IDS{1'b0}}};
    always_comb begin
      route = '1;
      for (int i = PRIV_IDS; i < NUM_IRQ; i++) route[i] = tgt[i][c];
    end
    assign en_v = {en_s, en_p[c]};
    assign pend = ({lat_s, lat_p[c]} | (lvl & ~edge_cfg)) & ~{act_s, act_p[c]};
    assign elig = pend & en_v & route & {NUM_IRQ{ctrl_en}};
    assign pend_all[c] = pend;
    assign en_all[c]   = en_v;

    irqd_prio_pick #(.N(NUM_IRQ), .IDW(IDW)) u_pick (
      .clk(clk), .rst(rst), .elig(elig), .prio(prio),
      .win_valid(win_v), .win_id(win_id), .win_prio(win_pr));

    always_ff @(posedge clk) begin
      if (rst) begin
        hv_q  <= 1'b0;
        hid_q <= '0;
        hpr_q <= '0;
      end else begin
        hv_q  <= win_v;
        hid_q <= win_id;
        hpr_q <= win_pr;
      end
    end

    assign hp_valid[c]                 = hv_q;
    assign hp_id[c*IDW +: IDW]         = hid_q;
    assign hp_prio[c*PRIO_W +: PRIO_W] = hpr_q;

    // R8: forwarding disabled means nothing is presented next cycle
    p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
      !ctrl_en |=> !hv_q);
    // R9: a software trigger aimed at this CPU leaves its pending latch set
    p_swi_sets_r9: assert property (@(posedge clk) disable iff (rst)
      (swi_wr && req_wdata[16+c]) |=> lat_p[c][$past(req_wdata[3:0])]);
  end

  // R12: every read gets a response one cycle later, and only reads do
  p_rsp_after_read_r12: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);
  p_rsp_only_read_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd));
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb_top;
  localparam int NCPU = 2;
  localparam int NIRQ = 64;
  localparam int IDW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic        req_ready;
  logic [0:0]  req_cpu = '0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] irq_in = '0;
  logic [31:0] ppi_in = '0;
  logic [1:0]  ack_valid = '0, eoi_valid = '0;
  logic [11:0] ack_id = '0, eoi_id = '0;
  logic [1:0]  hp_valid;
  logic [11:0] hp_id;
  logic [15:0] hp_prio;

  irq_distributor #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cpu(req_cpu), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_in(irq_in), .ppi_in(ppi_in), .ack_valid(ack_valid), .ack_id(ack_id),
    .eoi_valid(eoi_valid), .eoi_id(eoi_id), .hp_valid(hp_valid),
    .hp_id(hp_id), .hp_prio(hp_prio));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R12 unexpected response", 32'h1, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rsp_rdata, e);
      end
    end
  end

  task automatic reg_wr(int cpu, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_cpu = 1'(cpu); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic reg_rd(string req, int cpu, logic [7:0] a, logic [31:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_cpu = 1'(cpu); req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R12 response timing", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_hp(string req, int c, bit v, int id, int pr);
    chk({req, " valid"}, {31'b0, hp_valid[c]}, {31'b0, v});
    if (v) begin
      chk({req, " id"}, 32'(hp_id[c*IDW +: IDW]), 32'(id));
      chk({req, " prio"}, 32'(hp_prio[c*8 +: 8]), 32'(pr));
    end
  endtask

  task automatic do_ack(int c, int id);
    @(negedge clk);
    ack_valid[c] = 1; ack_id[c*IDW +: IDW] = 6'(id);
    @(negedge clk);
    ack_valid[c] = 0;
  endtask

  task automatic do_eoi(int c, int id);
    @(negedge clk);
    eoi_valid[c] = 1; eoi_id[c*IDW +: IDW] = 6'(id);
    @(negedge clk);
    eoi_valid[c] = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      done = 1;
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_hp("R1 cpu0", 0, 0, 0, 0);
    chk_hp("R1 cpu1", 1, 0, 0, 0);
    reg_rd("R1 ctrl", 0, 8'h00, 32'h0);
    reg_rd("R1 enable word0", 0, 8'h08, 32'h0);
    reg_rd("R1 enable word1", 0, 8'h09, 32'h0);
    // R4 type word, read-only
    reg_rd("R4 type", 0, 8'h01, 32'h1);
    reg_wr(0, 8'h01, 32'hFFFF_FFFF);
    reg_rd("R4 type after write", 0, 8'h01, 32'h1);
    // R5 priority lanes
    reg_wr(0, 8'h48, 32'h2020_3010);
    reg_rd("R5 priority readback", 0, 8'h48, 32'h2020_3010);
    reg_wr(0, 8'h41, 32'h0000_0800);
    // R2 set/clear enables, zero bits inert
    reg_wr(0, 8'h09, 32'h0000_000F);
    reg_wr(0, 8'h11, 32'h0000_0000);
    reg_rd("R2 zero clear inert", 0, 8'h09, 32'h0000_000F);
    reg_rd("R2 clear word reads enables", 0, 8'h11, 32'h0000_000F);
    // R3 banking of low IDs
    reg_wr(0, 8'h08, 32'h0001_0000);
    reg_rd("R3 other cpu copy", 1, 8'h08, 32'h0);
    reg_rd("R3 own cpu copy", 0, 8'h08, 32'h0001_0000);
    // R6 routing bytes
    reg_rd("R6 private bytes cpu1", 1, 8'h80, 32'h0202_0202);
    reg_rd("R6 private bytes cpu0", 0, 8'h80, 32'h0101_0101);
    reg_wr(0, 8'h88, 32'h0101_0101);
    reg_rd("R6 routing readback", 0, 8'h88, 32'h0101_0101);
    reg_wr(0, 8'h89, 32'hFFFF_FFFF);
    reg_rd("R6 unused routing bits", 0, 8'h89, 32'h0303_0303);
    // R10 selection with all four shared lines high
    reg_wr(0, 8'h00, 32'h1);
    irq_in[3:0] = 4'hF;
    settle();
    chk_hp("R10 lowest prio value", 0, 1, 32, 8'h10);
    chk_hp("R6 not routed to cpu1", 1, 0, 0, 0);
    // R8 gating keeps state
    reg_wr(0, 8'h00, 32'h0);
    settle();
    chk_hp("R8 gated cpu0", 0, 0, 0, 0);
    chk_hp("R8 gated cpu1", 1, 0, 0, 0);
    reg_rd("R8 state kept", 0, 8'h09, 32'h0000_000F);
    reg_wr(0, 8'h00, 32'h1);
    // R10 tie and R7 level drop
    irq_in[0] = 1'b0;
    settle();
    chk_hp("R10 tie lower id", 0, 1, 34, 8'h20);
    reg_wr(0, 8'h11, 32'h0000_0004);
    reg_rd("R2 clear one bit", 0, 8'h09, 32'h0000_000B);
    settle();
    chk_hp("R10 after disable", 0, 1, 35, 8'h20);
    // R11 acknowledge and completion
    do_ack(0, 35);
    settle();
    chk_hp("R11 active removed", 0, 1, 33, 8'h30);
    do_eoi(0, 35);
    settle();
    chk_hp("R11 completion restores", 0, 1, 35, 8'h20);
    // R6 reroute id35 to cpu1
    reg_wr(0, 8'h88, 32'h0201_0101);
    settle();
    chk_hp("R6 rerouted cpu1", 1, 1, 35, 8'h20);
    chk_hp("R6 rerouted cpu0", 0, 1, 33, 8'h30);
    // R7 level lines low
    irq_in = '0;
    settle();
    chk_hp("R7 level low cpu0", 0, 0, 0, 0);
    chk_hp("R7 level low cpu1", 1, 0, 0, 0);
    // R7 trigger configuration
    reg_wr(0, 8'h22, 32'h0000_0008);
    reg_rd("R7 config readback", 0, 8'h22, 32'h0000_0008);
    reg_wr(0, 8'h20, 32'h0);
    reg_rd("R7 sgi fixed edge", 0, 8'h20, 32'hAAAA_AAAA);
    reg_rd("R7 ppi config reset", 0, 8'h21, 32'h0);
    @(negedge clk); irq_in[1] = 1'b1;
    @(negedge clk); irq_in[1] = 1'b0;
    settle();
    chk_hp("R7 edge latched", 0, 1, 33, 8'h30);
    do_ack(0, 33);
    settle();
    chk_hp("R7 acked not shown", 0, 0, 0, 0);
    do_eoi(0, 33);
    settle();
    chk_hp("R7 latch cleared by ack", 0, 0, 0, 0);
    // R9 software trigger on cpu1 only
    reg_wr(1, 8'h08, 32'h0000_0020);
    reg_wr(0, 8'h02, 32'h0002_0005);
    settle();
    chk_hp("R9 swi on cpu1", 1, 1, 5, 8'h08);
    chk_hp("R9 swi not on cpu0", 0, 0, 0, 0);
    reg_rd("R9 pending cpu0", 0, 8'h18, 32'h0);
    reg_rd("R3 pending cpu1", 1, 8'h18, 32'h0000_0020);
    // R3 private line enabled only on cpu0
    ppi_in[16] = 1'b1;
    settle();
    chk_hp("R3 cpu1 private disabled", 1, 1, 5, 8'h08);
    chk_hp("R3 cpu0 idle", 0, 0, 0, 0);
    ppi_in[0] = 1'b1;
    settle();
    chk_hp("R3 cpu0 private line", 0, 1, 16, 8'h00);
    settle();
    chk("R12 scoreboard drained", 32'(exp_q.size()), 32'h0);
    chk("R12 ready", {31'b0, req_ready}, 32'h1);
    if (!done) begin
      done = 1;
      finish_run();
    end
  end
endmodule